// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block holds a small table of outbound translation windows that maps addresses seen on the local (AXI-side) bus onto addresses for the PCIe side. Each window is programmed through a plain 32-bit register write port. It has an enable flag, a transaction kind (configuration, I/O or memory), a 64-bit size mask, a 64-bit local base and a 64-bit remote base. Software programs the size mask as the bitwise inverse of (size − 1).

A lookup request carries one 64-bit local address. One cycle later the block reports which window matched, the translated remote address and the transaction kind, or it flags a decode error. Configuration windows need no special path. The bus, device and function numbers are written into the low remote-base word, and the usual merge of remote base and in-window offset carries them into the upper address bits. Building the PCIe transactions themselves is left to the logic downstream.

Top module: `xlat_win_table`

## Requirements
- R1: After reset every window is disabled, so every lookup returns a decode error until a window is enabled.
- R2: A lookup address hits window w when w is enabled and ((addr XOR base) AND mask) is zero over all 64 bits. Mask bits [31:10] come from the control word, mask bits [63:32] come from the window's extended mask register, and mask bits [9:0] are always zero.
- R3: On a hit, rsp_addr equals remote_base OR (addr AND NOT mask), using the full 64-bit remote base.
- R4: The control word holds enable at bit 0 and kind at bits [2:1], with the encoding 0 = configuration, 1 = I/O, 2 = memory. rsp_kind returns the kind of the winning window. A window of kind 3 never hits.
- R5: When several windows hit, the lowest-numbered one wins, and rsp_win gives its index.
- R6: On a miss, rsp_err is 1 and rsp_hit, rsp_addr, rsp_kind and rsp_win are all 0. Outside a response, rsp_hit and rsp_err are both 0.
- R7: Register map (byte addresses; bits [1:0] are ignored). Window w has control at 0x000+16w, local base low at +4 (bits [1:0] stored as 0), remote base low at +8 and remote base high at +12. Its extended mask high is at 0x100+4w and its local base high is at 0x140+4w. A write that selects a window index of NUM_WIN or above changes nothing.
- R8: rsp_valid follows req_valid by exactly one cycle. A register write is seen by lookups presented in the following cycle, but not by a lookup in the same cycle.
- R9: With a configuration window whose low remote word holds bus<<24 | device<<19 | function<<16, the translated address carries those fields at the same bit positions, plus the 4 KB offset below them.
- R10: Clearing the enable bit of a window removes it from matching, and a lower-priority overlapping window then takes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Local address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_err | output | 1 | Decode error (no window matched) |
| rsp_addr | output | 64 | Translated remote address |
| rsp_kind | output | 2 | Transaction kind of the winning window |
| rsp_win | output | 3 | Index of the winning window |

## Verification
A stored field corrupted inside a window shows up at the ports on the first lookup that reaches that window. A bad mask or base moves the hit/miss edge, a bad remote base alters rsp_addr, and a bad kind alters rsp_kind, each one cycle after the request. Faults in the priority or register decode show up as the wrong rsp_win, or as a write that lands on a neighbouring window, the next time overlapping or adjacent windows are looked up. Because of this, the scenarios probe addresses on both sides of each window edge and place windows next to each other.

// File: rtl/xlat_win_pkg.sv
package xlat_win_pkg;
  localparam int XW_AW   = 64;
  localparam int XW_DW   = 32;
  localparam int XW_CFGW = 9;

  typedef enum logic [1:0] {
    XW_CFG  = 2'd0,
    XW_IO   = 2'd1,
    XW_MEM  = 2'd2,
    XW_RSVD = 2'd3
  } xw_kind_e;

  typedef struct packed {
    logic             en;
    xw_kind_e         kind;
    logic [XW_AW-1:0] mask;
    logic [XW_AW-1:0] lbase;
    logic [XW_AW-1:0] rbase;
  } xw_entry_t;

  // word select inside a window's 16-byte block
  localparam logic [1:0] XW_W_CTRL  = 2'd0;
  localparam logic [1:0] XW_W_LBLO  = 2'd1;
  localparam logic [1:0] XW_W_RBLO  = 2'd2;
  localparam logic [1:0] XW_W_RBHI  = 2'd3;
endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
  import xlat_win_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [XW_CFGW-1:0]            addr,
  input  logic [XW_DW-1:0]              wdata,
  output xw_entry_t [NUM_WIN-1:0]       win_o
);
  logic [1:0] word;
  logic       ext_region;
  logic       ext_is_base;
  logic       unused_bits;

  assign word        = addr[3:2];
  assign ext_region  = addr[8] & ~addr[7];
  assign ext_is_base = addr[6];
  assign unused_bits = ^{addr[1:0], wdata[9:3]};

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [3:0] GI = 4'(g);
    logic main_sel;
    logic ext_sel;
    xw_entry_t ent_q;

    assign main_sel = we & ~addr[8] & (addr[7:4] == GI);
    assign ext_sel  = we & ext_region & (addr[5:2] == GI);

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= '0;
      end else if (main_sel) begin
        case (word)
          XW_W_CTRL: begin
            ent_q.en         <= wdata[0];
            ent_q.kind       <= xw_kind_e'(wdata[2:1]);
            ent_q.mask[31:0] <= {wdata[31:10], 10'd0};
          end
          XW_W_LBLO: ent_q.lbase[31:0] <= {wdata[31:2], 2'b00};
          XW_W_RBLO: ent_q.rbase[31:0] <= wdata;
          default:   ent_q.rbase[63:32] <= wdata;
        endcase
      end else if (ext_sel) begin
        if (ext_is_base) ent_q.lbase[63:32] <= wdata;
        else             ent_q.mask[63:32]  <= wdata;
      end
    end

    assign win_o[g] = ent_q;
  end
endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
  import xlat_win_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  xw_entry_t [NUM_WIN-1:0] win_i,
  input  logic [XW_AW-1:0]        addr,
  output logic [NUM_WIN-1:0]      hit
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic in_range;
    assign in_range = (((addr ^ win_i[g].lbase) & win_i[g].mask) == '0);
    assign hit[g]   = win_i[g].en & (win_i[g].kind != XW_RSVD) & in_range;
  end
endmodule

// File: rtl/xlat_win_prio.sv
module xlat_win_prio #(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] hit,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |hit;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_win_table.sv
module xlat_win_table
  import xlat_win_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [XW_CFGW-1:0]  cfg_addr,
  input  logic [XW_DW-1:0]    cfg_wdata,
  input  logic                req_valid,
  input  logic [XW_AW-1:0]    req_addr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_err,
  output logic [XW_AW-1:0]    rsp_addr,
  output logic [1:0]          rsp_kind,
  output logic [IDX_W-1:0]    rsp_win
);
  xw_entry_t [NUM_WIN-1:0] win_tab;
  logic [NUM_WIN-1:0]      hit_vec;
  logic                    any_hit;
  logic [IDX_W-1:0]        sel_idx;
  xw_entry_t               sel_ent;
  logic [XW_AW-1:0]        xlat_addr;

  xlat_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .win_o (win_tab)
  );

  xlat_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .win_i (win_tab),
    .addr  (req_addr),
    .hit   (hit_vec)
  );

  xlat_win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit (hit_vec),
    .any (any_hit),
    .idx (sel_idx)
  );

  assign sel_ent   = win_tab[sel_idx];
  assign xlat_addr = sel_ent.rbase | (req_addr & ~sel_ent.mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
      rsp_kind  <= '0;
      rsp_win   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & any_hit;
      rsp_err   <= req_valid & ~any_hit;
      if (req_valid && any_hit) begin
        rsp_addr <= xlat_addr;
        rsp_kind <= sel_ent.kind;
        rsp_win  <= sel_idx;
      end else begin
        rsp_addr <= '0;
        rsp_kind <= '0;
        rsp_win  <= '0;
      end
    end
  end
endmodule

// File: rtl/xlat_win_table_chk.sv
module xlat_win_table_chk #(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_err,
  input logic [63:0]      rsp_addr,
  input logic [1:0]       rsp_kind,
  input logic [IDX_W-1:0] rsp_win
);
  logic seen_we;
  always_ff @(posedge clk) begin
    if (rst)         seen_we <= 1'b0;
    else if (cfg_we) seen_we <= 1'b1;
  end

  assert_reset_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (!seen_we && rsp_valid) |-> rsp_err);

  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_kind != 2'd3));

  assert_win_range_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (int'(rsp_win) < NUM_WIN));

  assert_hit_xor_err_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_err));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_addr == '0 && rsp_kind == 2'd0 && rsp_win == '0));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_err));

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind xlat_win_table xlat_win_table_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_err   (rsp_err),
  .rsp_addr  (rsp_addr),
  .rsp_kind  (rsp_kind),
  .rsp_win   (rsp_win)
);

// File: tb/xlat_win_table_bench.sv
`timescale 1ns/1ps
module xlat_win_table_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_err;
  logic [63:0] rsp_addr;
  logic [1:0]  rsp_kind;
  logic [2:0]  rsp_win;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  xlat_win_table #(.NUM_WIN(8)) u_xlat_win_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_addr(rsp_addr), .rsp_kind(rsp_kind), .rsp_win(rsp_win)
  );

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int w, input logic en, input logic [1:0] kind,
                      input logic [63:0] size, input logic [63:0] lbase,
                      input logic [63:0] rbase);
    logic [63:0] m;
    m = ~(size - 64'd1);
    wr(9'(16*w + 4),  lbase[31:0]);
    wr(9'(9'h140 + 4*w), lbase[63:32]);
    wr(9'(16*w + 8),  rbase[31:0]);
    wr(9'(16*w + 12), rbase[63:32]);
    wr(9'(9'h100 + 4*w), m[63:32]);
    wr(9'(16*w), {m[31:10], 7'd0, kind, en});
  endtask

  task automatic check(input string tag, input logic [63:0] a,
                       input logic e_hit, input logic [63:0] e_addr,
                       input logic [1:0] e_kind, input logic [2:0] e_win);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_err !== !e_hit ||
        rsp_addr !== e_addr || rsp_kind !== e_kind || rsp_win !== e_win) begin
      n_bad++;
      $display("FAIL %s addr=%h: got v=%b hit=%b err=%b a=%h k=%0d w=%0d exp hit=%b a=%h k=%0d w=%0d",
               tag, a, rsp_valid, rsp_hit, rsp_err, rsp_addr, rsp_kind, rsp_win,
               e_hit, e_addr, e_kind, e_win);
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 idle outputs: v=%b h=%b e=%b exp 0 0 0", rsp_valid, rsp_hit, rsp_err);
    end
    check("R1 reset miss low", 64'h0, 1'b0, 64'h0, 2'd0, 3'd0);
    check("R1 reset miss high", 64'hFFFF_0000_1234_5678, 1'b0, 64'h0, 2'd0, 3'd0);
  endtask

  task automatic t_basic_mem;
    prog(0, 1'b1, 2'd2, 64'h1_0000, 64'h0000_0001_2345_0000, 64'h0000_00AB_0000_0000);
    check("R3 mem hit", 64'h0000_0001_2345_1234, 1'b1, 64'h0000_00AB_0000_1234, 2'd2, 3'd0);
    check("R2 last byte in window", 64'h0000_0001_2345_FFFF, 1'b1, 64'h0000_00AB_0000_FFFF, 2'd2, 3'd0);
    check("R2 one past window", 64'h0000_0001_2346_0000, 1'b0, 64'h0, 2'd0, 3'd0);
    check("R2 base high word differs", 64'h0000_0002_2345_0010, 1'b0, 64'h0, 2'd0, 3'd0);
  endtask

  task automatic t_wide_mask;
    prog(1, 1'b1, 2'd1, 64'h2_0000_0000, 64'h0000_0004_0000_0000, 64'h1000_0000_0000_0000);
    check("R2 mask high inside", 64'h0000_0005_2345_6789, 1'b1, 64'h1000_0001_2345_6789, 2'd1, 3'd1);
    check("R2 mask high outside", 64'h0000_0006_0000_0000, 1'b0, 64'h0, 2'd0, 3'd0);
  endtask

  task automatic t_priority;
    prog(3, 1'b1, 2'd2, 64'h1000_0000, 64'h8000_0000, 64'h0000_3000_0000_0000);
    prog(2, 1'b1, 2'd1, 64'h1000, 64'h8010_0000, 64'h7700_0000);
    check("R5 lower index wins", 64'h8010_0ABC, 1'b1, 64'h7700_0ABC, 2'd1, 3'd2);
    check("R5 outer window", 64'h8020_0004, 1'b1, 64'h0000_3000_0020_0004, 2'd2, 3'd3);
  endtask

  task automatic t_config;
    prog(4, 1'b1, 2'd0, 64'h1000, 64'hE000_0000, {32'h0, (32'd3 << 24) | (32'd5 << 19) | (32'd2 << 16)});
    check("R9 bdf 3/5/2", 64'hE000_0104, 1'b1, 64'h032A_0104, 2'd0, 3'd4);
    wr(9'h048, (32'd7 << 24) | (32'd1 << 16));
    check("R9 bdf 7/0/1", 64'hE000_0FFC, 1'b1, 64'h0701_0FFC, 2'd0, 3'd4);
  endtask

  task automatic t_reserved_kind;
    prog(6, 1'b1, 2'd3, 64'h1000, 64'hF000_0000, 64'h1234_0000);
    check("R4 kind 3 never hits", 64'hF000_0010, 1'b0, 64'h0, 2'd0, 3'd0);
  endtask

  task automatic t_disable;
    wr(9'h020, 32'hFFFF_F000 | 32'h2);
    check("R10 disabled falls through", 64'h8010_0ABC, 1'b1, 64'h0000_3000_0010_0ABC, 2'd2, 3'd3);
  endtask

  task automatic t_bad_index;
    wr(9'h084, 32'h0);
    wr(9'h120, 32'h0);
    wr(9'h080, 32'hFFFF_F000 | 32'h5);
    check("R7 window 8 write ignored", 64'h0000_0ABC, 1'b0, 64'h0, 2'd0, 3'd0);
    check("R7 neighbour intact", 64'h0000_0001_2345_0042, 1'b1, 64'h0000_00AB_0000_0042, 2'd2, 3'd0);
  endtask

  task automatic t_write_timing;
    prog(7, 1'b0, 2'd2, 64'h1000, 64'hD000_0000, 64'h5500_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'h070; cfg_wdata = 32'hFFFF_F000 | 32'h5;
    req_valid = 1'b1; req_addr = 64'hD000_0020;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_err !== 1'b1) begin
      n_bad++;
      $display("FAIL R8 same-cycle write: v=%b err=%b exp v=1 err=1", rsp_valid, rsp_err);
    end
    check("R8 write seen next cycle", 64'hD000_0020, 1'b1, 64'h5500_0020, 2'd2, 3'd7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_mem();
    t_wide_mask();
    t_priority();
    t_config();
    t_reserved_kind();
    t_disable();
    t_bad_index();
    t_write_timing();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule